// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block turns a virtual page number into a physical page number. It does so by walking a hashed translation table that sits in memory. The table is split into slots, and every slot is a group of `WAYS` consecutive entry words. A request hashes the page number to a primary slot and reads that slot's entries one at a time. It stops at the first valid entry whose tag equals the page number. If the primary slot has no such entry, the engine derives an alternate slot from the same hash and walks it in the same way. It answers with a hit and the physical page number, or with a miss that software then resolves from its own full table.

A client presents a page number and the table base on a valid/ready port. The engine takes the request when it is idle and drops `req_ready` until it has answered. The answer comes back as a one-cycle `rsp_valid` pulse. Table memory is reached through a simple read port that has one read in flight at a time. The memory may return data any number of cycles after the read request.

The state machine has four states. `ST_IDLE` waits for a request and moves to `ST_ISSUE` on acceptance. `ST_ISSUE` raises a read for one cycle and moves to `ST_WAIT`. `ST_WAIT` holds until read data returns, then does one of three things: it moves to `ST_DONE` on a match, moves to `ST_DONE` after the last entry of the alternate slot, or returns to `ST_ISSUE` for the next entry (or the first entry of the alternate slot). `ST_DONE` drives the response for one cycle and returns to `ST_IDLE`.

Top module: `hpt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0.
- R2: The primary slot index is the XOR of the upper half and lower half of the page number, keeping only the low `IDX_W` bits. With `VPN_W`=16 this is `(vpn[15:8]^vpn[7:0])` masked. An entry's address is `base + slot*WAYS + way`, and the first read of a lookup uses way 0 of the primary slot.
- R3: Entries are read one at a time in increasing way order. A new read is issued only after the previous read's data has returned, and no read is issued while the engine is idle.
- R4: An entry word carries the physical page number in bits [PPN_W-1:0], the tag in bits [PPN_W+VPN_W-1:PPN_W], and a valid flag in the top bit. An entry matches only when its valid flag is 1 and its tag equals the page number. An invalid entry with an equal tag is skipped.
- R5: The search stops at the first matching entry. The response then has `rsp_hit`=1 and that entry's physical page number, and no further reads are made for the lookup.
- R6: When all `WAYS` entries of the primary slot fail, the alternate slot (the bitwise inverse of the primary index, masked to `IDX_W` bits) is searched from way 0 upward.
- R7: When both slots fail, the response has `rsp_hit`=0 and `rsp_ppn`=0, after exactly `2*WAYS` reads.
- R8: `req_ready` is 0 from the cycle after acceptance through the response cycle. A request presented during that time is ignored. `rsp_valid` is high for exactly one cycle, after which `req_ready` returns to 1.
- R9: No lookup makes more than `2*WAYS` memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_vpn | input | VPN_W | Virtual page number to translate |
| tbl_base | input | ADDR_W | Word address of the table start, sampled at acceptance |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_ppn | output | PPN_W | Physical page number on a hit, 0 on a miss |
| mem_rd_req | output | 1 | Read request to table memory |
| mem_rd_addr | output | ADDR_W | Word address of the entry being read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 1+VPN_W+PPN_W | Entry word |

## Verification
The bench builds the engine with a 16-bit page number, a 12-bit physical page number, 16 slots of 8 ways, and a 10-bit word address. With these values a full two-slot walk takes 16 reads, and the bench's 1024-word memory model can place a table at several distinct bases. The primary and alternate slots always differ, so every entry position of both slots can be seeded and the exact address of each read compared.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } hpt_state_e;
endpackage

// File: rtl/hpt_hash.sv
// Folds the page number into a primary slot index and derives the alternate.
module hpt_hash #(
    parameter int VPN_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] prim_idx,
    output logic [IDX_W-1:0] alt_idx
);
    localparam int LO_W = VPN_W / 2;
    localparam int HI_W = VPN_W - LO_W;

    logic [HI_W-1:0] fold;

    assign fold = vpn[VPN_W-1:LO_W] ^ HI_W'(vpn[LO_W-1:0]);

    generate
        if (IDX_W < HI_W) begin : g_trim
            logic unused_fold_hi;
            assign prim_idx       = fold[IDX_W-1:0];
            assign unused_fold_hi = ^fold[HI_W-1:IDX_W];
        end else if (IDX_W == HI_W) begin : g_exact
            assign prim_idx = fold;
        end else begin : g_pad
            assign prim_idx = {{(IDX_W-HI_W){1'b0}}, fold};
        end
    endgenerate

    assign alt_idx = ~prim_idx;
endmodule

// File: rtl/hpt_slot_addr.sv
// Entry address: table base plus slot*WAYS plus way (WAYS a power of two).
module hpt_slot_addr #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int WAY_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  slot,
    input  logic [WAY_W-1:0]  way,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFS_W = IDX_W + WAY_W;

    logic [OFS_W-1:0] ofs;

    assign ofs  = {slot, way};
    assign addr = base + ADDR_W'(ofs);
endmodule

// File: rtl/hpt_entry_match.sv
// Splits an entry word and compares its tag against the page number.
module hpt_entry_match #(
    parameter int VPN_W = 16,
    parameter int PPN_W = 12
) (
    input  logic [VPN_W+PPN_W:0] entry,
    input  logic [VPN_W-1:0]     vpn,
    output logic                 hit,
    output logic [PPN_W-1:0]     ppn
);
    logic             ent_valid;
    logic [VPN_W-1:0] ent_tag;

    assign ent_valid = entry[VPN_W+PPN_W];
    assign ent_tag   = entry[VPN_W+PPN_W-1:PPN_W];
    assign ppn       = entry[PPN_W-1:0];
    assign hit       = ent_valid && (ent_tag == vpn);
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int VPN_W  = 16,
    parameter int PPN_W  = 12,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 10,
    parameter int WAYS   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [ADDR_W-1:0]        tbl_base,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [PPN_W-1:0]         rsp_ppn,
    output logic                     mem_rd_req,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic                     mem_rd_valid,
    input  logic [VPN_W+PPN_W:0]     mem_rd_data
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    hpt_state_e        st_q, st_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] base_q;
    logic [WAY_W-1:0]  way_q;
    logic              alt_q;
    logic              hit_q;
    logic [PPN_W-1:0]  ppn_q;

    logic [IDX_W-1:0]  prim_idx, alt_idx, slot_sel;
    logic              ent_hit;
    logic [PPN_W-1:0]  ent_ppn;
    logic              last_way;

    hpt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
        .vpn      (vpn_q),
        .prim_idx (prim_idx),
        .alt_idx  (alt_idx)
    );

    assign slot_sel = alt_q ? alt_idx : prim_idx;

    hpt_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_addr (
        .base (base_q),
        .slot (slot_sel),
        .way  (way_q),
        .addr (mem_rd_addr)
    );

    hpt_entry_match #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
        .entry (mem_rd_data),
        .vpn   (vpn_q),
        .hit   (ent_hit),
        .ppn   (ent_ppn)
    );

    assign last_way = (way_q == LAST_WAY);

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    if (ent_hit || (last_way && alt_q)) st_d = ST_DONE;
                    else                                st_d = ST_ISSUE;
                end
            end
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            vpn_q  <= '0;
            base_q <= '0;
            way_q  <= '0;
            alt_q  <= 1'b0;
            hit_q  <= 1'b0;
            ppn_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                vpn_q  <= req_vpn;
                base_q <= tbl_base;
                way_q  <= '0;
                alt_q  <= 1'b0;
                hit_q  <= 1'b0;
                ppn_q  <= '0;
            end else if (st_q == ST_WAIT && mem_rd_valid) begin
                if (ent_hit) begin
                    hit_q <= 1'b1;
                    ppn_q <= ent_ppn;
                end else if (last_way) begin
                    way_q <= '0;
                    alt_q <= 1'b1;
                end else begin
                    way_q <= way_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (st_q == ST_IDLE);
        mem_rd_req = (st_q == ST_ISSUE);
        rsp_valid  = (st_q == ST_DONE);
        rsp_hit    = hit_q;
        rsp_ppn    = ppn_q;
    end
endmodule

// File: rtl/hpt_lookup_chk.sv
module hpt_lookup_chk #(
    parameter int PPN_W = 12,
    parameter int WAYS  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             mem_rd_req
);
    localparam int CW = $clog2(2 * WAYS + 2) + 1;

    logic [CW-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_cnt <= '0;
        else if (req_valid && req_ready) rd_cnt <= '0;
        else if (mem_rd_req)             rd_cnt <= rd_cnt + 1'b1;
    end

    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_req); // R3
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R3
    AST_MISS_FULL_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rd_cnt == CW'(2 * WAYS))); // R7
    AST_MISS_PPN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0)); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R8
    AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (rd_cnt < CW'(2 * WAYS))); // R9
endmodule

bind hpt_lookup hpt_lookup_chk #(.PPN_W(PPN_W), .WAYS(WAYS)) u_hpt_lookup_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ppn    (rsp_ppn),
    .mem_rd_req (mem_rd_req)
);

// File: tb/test_hpt_lookup.sv
`timescale 1ns/1ps
module test_hpt_lookup;
    localparam int VPN_W = 16, PPN_W = 12, IDX_W = 4, ADDR_W = 10, WAYS = 8;
    localparam int EW = 1 + VPN_W + PPN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [ADDR_W-1:0] tbl_base = '0;
    logic rsp_valid, rsp_hit;
    logic [PPN_W-1:0] rsp_ppn;
    logic mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [EW-1:0] mem_rd_data = '0;

    logic [EW-1:0] mem [0:1023];
    logic [ADDR_W-1:0] addr_log [0:255];
    int log_n = 0;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hpt_lookup #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WAYS(WAYS)) i_hpt_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .tbl_base(tbl_base), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ppn(rsp_ppn), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // Table memory model: one-cycle read latency, logs every read address
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_req) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem[mem_rd_addr];
            if (log_n < 256) addr_log[log_n] <= mem_rd_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] hprim(input logic [VPN_W-1:0] v);
        logic [7:0] f;
        f = v[15:8] ^ v[7:0];
        return f[IDX_W-1:0];
    endfunction

    function automatic logic [IDX_W-1:0] halt(input logic [VPN_W-1:0] v);
        return ~hprim(v);
    endfunction

    function automatic logic [EW-1:0] mk(input bit vld, input logic [VPN_W-1:0] tag, input logic [PPN_W-1:0] p);
        return {vld, tag, p};
    endfunction

    function automatic int eaddr(input int b, input logic [IDX_W-1:0] s, input int w);
        return b + int'(s) * WAYS + w;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    // Runs one lookup; optionally holds another request during the walk
    task automatic lookup(input logic [VPN_W-1:0] v, input int b, input bit hold,
                          input logic [VPN_W-1:0] v2, output bit h, output logic [PPN_W-1:0] p,
                          output int st, output int n, output bit busy_ok);
        int cyc;
        @(negedge clk);
        req_vpn = v; tbl_base = ADDR_W'(b); req_valid = 1'b1; st = log_n;
        @(negedge clk);
        if (hold) begin req_vpn = v2; tbl_base = '0; end
        else req_valid = 1'b0;
        busy_ok = 1'b1; cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 200, "R8 response arrives", cyc, 0);
        if (req_ready) busy_ok = 1'b0;
        h = rsp_hit; p = rsp_ppn; n = log_n - st;
        req_valid = 1'b0;
        @(negedge clk);
        if (rsp_valid || !req_ready) busy_ok = 1'b0;
    endtask

    task automatic chk_addrs(input int st, input int n, input int b, input logic [VPN_W-1:0] v, input string tag);
        bit ok = 1'b1;
        int fa = 0, fe = 0;
        for (int i = 0; i < n; i++) begin
            int e;
            e = (i < WAYS) ? eaddr(b, hprim(v), i) : eaddr(b, halt(v), i - WAYS);
            if (ok && int'(addr_log[st + i]) != e) begin ok = 1'b0; fa = int'(addr_log[st + i]); fe = e; end
        end
        chk(ok, tag, fa, fe);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(mem_rd_req == 1'b0, "R1 mem_rd_req after reset", mem_rd_req, 0);
    endtask

    task automatic t_hit_first();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h3A5C;
        clear_mem();
        mem[eaddr(0, hprim(v), 0)] = mk(1, v, 12'hABC);
        lookup(v, 0, 0, '0, h, p, st, n, bz);
        chk(h == 1'b1, "R5 hit way0", h, 1);
        chk(p == 12'hABC, "R5 ppn way0", p, 12'hABC);
        chk(n == 1, "R5 reads way0", n, 1);
        chk_addrs(st, n, 0, v, "R2 primary address way0");
        chk(bz, "R8 busy window way0", bz, 1);
    endtask

    task automatic t_hit_last();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h1234;
        clear_mem();
        for (int w = 0; w < WAYS - 1; w++) mem[eaddr(64, hprim(v), w)] = mk(1, v ^ 16'h0100, 12'h010 + 12'(w));
        mem[eaddr(64, hprim(v), WAYS - 1)] = mk(1, v, 12'h777);
        lookup(v, 64, 0, '0, h, p, st, n, bz);
        chk(h && p == 12'h777, "R3 hit last way", p, 12'h777);
        chk(n == WAYS, "R3 reads last way", n, WAYS);
        chk_addrs(st, n, 64, v, "R3 sequential order");
    endtask

    task automatic t_alt_slot();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'hBEEF;
        clear_mem();
        for (int w = 0; w < WAYS; w++) mem[eaddr(256, hprim(v), w)] = mk(1, v + 16'(w + 1), 12'h100);
        mem[eaddr(256, halt(v), 3)] = mk(1, v, 12'h5A5);
        lookup(v, 256, 0, '0, h, p, st, n, bz);
        chk(h && p == 12'h5A5, "R6 alternate slot hit", p, 12'h5A5);
        chk(n == WAYS + 4, "R6 reads alternate", n, WAYS + 4);
        chk_addrs(st, n, 256, v, "R6 alternate addresses");
    endtask

    task automatic t_miss();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h0F0F;
        clear_mem();
        for (int w = 0; w < WAYS; w++) begin
            mem[eaddr(128, hprim(v), w)] = mk(w[0], w[0] ? v ^ 16'h8000 : v, 12'hFFF);
            mem[eaddr(128, halt(v), w)]  = mk(0, v, 12'hEEE);
        end
        lookup(v, 128, 0, '0, h, p, st, n, bz);
        chk(h == 1'b0, "R7 miss flag", h, 0);
        chk(p == '0, "R7 miss ppn", p, 0);
        chk(n == 2 * WAYS, "R9 miss read count", n, 2 * WAYS);
        chk_addrs(st, n, 128, v, "R7 full walk addresses");
    endtask

    task automatic t_invalid_skip();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h4C21;
        clear_mem();
        mem[eaddr(512, hprim(v), 1)] = mk(0, v, 12'h111);
        mem[eaddr(512, hprim(v), 5)] = mk(1, v, 12'h555);
        lookup(v, 512, 0, '0, h, p, st, n, bz);
        chk(h && p == 12'h555, "R4 invalid entry skipped", p, 12'h555);
        chk(n == 6, "R4 reads past invalid", n, 6);
    endtask

    task automatic t_first_wins();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h9003;
        clear_mem();
        mem[eaddr(32, hprim(v), 2)] = mk(1, v, 12'h222);
        mem[eaddr(32, hprim(v), 4)] = mk(1, v, 12'h444);
        mem[eaddr(32, halt(v), 0)]  = mk(1, v, 12'h999);
        lookup(v, 32, 0, '0, h, p, st, n, bz);
        chk(h && p == 12'h222, "R5 first match wins", p, 12'h222);
        chk(n == 3, "R5 stop after match", n, 3);
    endtask

    task automatic t_busy_ignore();
        bit h, bz; logic [PPN_W-1:0] p; int st, n;
        logic [VPN_W-1:0] v = 16'h7777;
        logic [VPN_W-1:0] v2 = 16'h0102;
        clear_mem();
        mem[eaddr(0, hprim(v2), 0)] = mk(1, v2, 12'h321);
        lookup(v, 768, 1, v2, h, p, st, n, bz);
        chk(bz, "R8 ready low while busy", bz, 1);
        chk(h == 1'b0 && p == '0, "R8 held request ignored", p, 0);
        chk(n == 2 * WAYS, "R8 walk unchanged by held request", n, 2 * WAYS);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_first();
        t_hit_last();
        t_alt_slot();
        t_miss();
        t_invalid_skip();
        t_first_wins();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule